// File: doc/BRIEF.md
# Real-time clock prescaler with digital trim and frequency probe

This block sits at the front of a real-time clock. It counts pulses from a 32,768 Hz oscillator, emits a one-cycle pulse at the end of every second, and keeps a 0 to 59 seconds count. A signed calibration value moves the length of one second in each calibration window by a whole number of oscillator ticks. At the default window of 15 seconds, one step is 1/(32768*15), about 2.03 ppm. A fast crystal is corrected with negative steps, which lengthen the trimmed second. A slow crystal is corrected with positive steps, which shorten it.

For bench tuning there is a frequency-test mode. When its enable bit is set, bit 0 of the seconds read data no longer carries the seconds LSB. While the seconds location stays selected and the read-hold bit is clear, bit 0 carries a 512 Hz square wave. This wave comes from a free-running divider that is never trimmed, so it shows the raw crystal rate. The enable bit sits in the days register and is only accepted while the write-hold bit is set. Clearing it brings back the normal seconds value.

Configuration uses a small write port with three registers, selected by `cfg_sel`: 0 is control, 1 is calibration and 2 is days. The seconds value is read on `dq` while `rd_sec` is held high.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: Reset sets the state as follows: `sec_count` = 0, `sec_pulse` = 0, calibration = 0, test enable = 0, write-hold = 0 and read-hold = 0. `dq` reads 0.
- R2: With a calibration magnitude of 0, every second lasts exactly TICKS_PER_SEC (32768) oscillator ticks.
  - `sec_pulse` is high for one cycle, in the cycle after the edge that takes the last tick of the second.
  - At the same time `sec_count` advances by one, wrapping from 59 to 0.
- R3: The calibration register (`cfg_sel` = 1) holds the magnitude in bits 4:0 and the sign in bit 5. Sign 0 means negative steps: the trimmed second lasts 32768 + magnitude ticks. For example, 6'b001010 gives 32778.
- R4: Sign 1 means positive steps: the trimmed second lasts 32768 - magnitude ticks.
- R5: Only the first second of each window of CAL_WINDOW seconds is trimmed. Windows are counted from reset, so the trimmed seconds are those whose index is a multiple of CAL_WINDOW. Every other second lasts 32768 ticks, whatever the calibration value.
- R6: The probe is bit 5 of a count of all oscillator ticks since reset.
  - It goes high after tick 32 and low after tick 64.
  - Its period is 64 ticks, which is 512 Hz from a 32,768 Hz oscillator.
- R7: When `rd_sec` = 1, test enable = 1 and read-hold = 0, `dq` = {2'b00, sec_count[5:1], probe}.
- R8: The test enable is bit 6 of the days register (`cfg_sel` = 2). A write to it takes effect only if write-hold (control bit 7, `cfg_sel` = 0) was already 1 before that write. Otherwise the write is ignored.
- R9: Clearing test enable under write-hold returns `dq` to {2'b00, sec_count}.
- R10: Read-hold is control bit 6.
  - Setting it captures `sec_count`. While it stays set, `dq` shows the captured value and not the probe.
  - Clearing it returns `dq` to the live value.
- R11: `dq` is 0 whenever `rd_sec` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle pulse per 32,768 Hz oscillator period |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 calibration, 2 days |
| cfg_wdata | input | 8 | Configuration write data |
| rd_sec | input | 1 | Seconds location selected for reading (held) |
| dq | output | 8 | Seconds read data, or the probe on bit 0 in test mode |
| sec_pulse | output | 1 | One-cycle pulse at the end of each second |
| sec_count | output | 6 | Seconds count, 0 to 59 |

## Verification
A wrong prescaler terminal value or a wrong window phase shows at the ports as a wrong spacing between `sec_pulse` events. The error appears at the end of the affected second, and a window phase error appears within CAL_WINDOW seconds. A wrong probe divider shows on `dq[0]` within 32 ticks. A faulty guard on the test-enable bit, or a faulty read-hold capture, changes `dq` in the cycle after the offending write. The bench uses a two-second window so that trimmed and untrimmed seconds can both be observed.

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int CAL_WINDOW    = 15,
  parameter int MAG_W         = 5,
  parameter int PROBE_BIT     = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       cfg_we,
  input  logic [1:0] cfg_sel,
  input  logic [7:0] cfg_wdata,
  input  logic       rd_sec,
  output logic [7:0] dq,
  output logic       sec_pulse,
  output logic [5:0] sec_count
);

  localparam int PRE_W = $clog2(TICKS_PER_SEC + 2**MAG_W);
  localparam int WIN_W = (CAL_WINDOW > 1) ? $clog2(CAL_WINDOW) : 1;
  localparam logic [PRE_W-1:0] BASE_LAST = PRE_W'(TICKS_PER_SEC - 1);
  localparam logic [WIN_W-1:0] WIN_LAST  = WIN_W'(CAL_WINDOW - 1);
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_CAL  = 2'd1;
  localparam logic [1:0] SEL_DAYS = 2'd2;

  logic [PRE_W-1:0]   pre_cnt;
  logic [PRE_W-1:0]   lim;
  logic [PRE_W-1:0]   step;
  logic [WIN_W-1:0]   win_cnt;
  logic [PROBE_BIT:0] raw_div;
  logic [MAG_W:0]     cal_r;
  logic [5:0]         snap;
  logic               whold, rhold, test_en;
  logic               probe, last;

  assign probe = raw_div[PROBE_BIT];
  assign step  = PRE_W'(cal_r[MAG_W-1:0]);

  always_comb begin
    lim = BASE_LAST;
    if (win_cnt == '0)
      lim = cal_r[MAG_W] ? BASE_LAST - step : BASE_LAST + step;
  end

  assign last = osc_tick && (pre_cnt >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt   <= '0;
      win_cnt   <= '0;
      raw_div   <= '0;
      cal_r     <= '0;
      snap      <= '0;
      whold     <= 1'b0;
      rhold     <= 1'b0;
      test_en   <= 1'b0;
      sec_pulse <= 1'b0;
      sec_count <= '0;
    end else begin
      sec_pulse <= last;
      if (osc_tick) begin
        raw_div <= raw_div + 1'b1;
        pre_cnt <= last ? '0 : pre_cnt + 1'b1;
      end
      if (last) begin
        win_cnt   <= (win_cnt == WIN_LAST) ? '0 : win_cnt + 1'b1;
        sec_count <= (sec_count == 6'd59) ? 6'd0 : sec_count + 6'd1;
      end
      if (cfg_we) begin
        case (cfg_sel)
          SEL_CTRL: begin
            whold <= cfg_wdata[7];
            rhold <= cfg_wdata[6];
            if (cfg_wdata[6] && !rhold) snap <= sec_count;
          end
          SEL_CAL:  cal_r <= cfg_wdata[MAG_W:0];
          SEL_DAYS: if (whold) test_en <= cfg_wdata[6];
          default: ;
        endcase
      end
    end
  end

  assign dq = !rd_sec ? 8'h00 :
              rhold   ? {2'b00, snap} :
              test_en ? {2'b00, sec_count[5:1], probe} :
                        {2'b00, sec_count};

endmodule

// File: rtl/rtc_trim_prescaler_chk.sv
module rtc_trim_prescaler_chk #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int MAG_W         = 5,
  parameter int PRE_W         = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             osc_tick,
  input logic             rd_sec,
  input logic [7:0]       dq,
  input logic             sec_pulse,
  input logic [5:0]       sec_count,
  input logic [PRE_W-1:0] pre_cnt,
  input logic             probe,
  input logic             test_en,
  input logic             whold,
  input logic             rhold
);

  p_pulse_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> $past(osc_tick));

  p_sec_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> sec_count == (($past(sec_count) == 6'd59) ? 6'd0 : $past(sec_count) + 6'd1));

  p_sec_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_pulse |-> $stable(sec_count));

  p_pre_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pre_cnt) < TICKS_PER_SEC + 2**MAG_W);

  p_probe_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(osc_tick) |-> $stable(probe));

  p_test_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en != $past(test_en)) |-> $past(whold));

  p_hold_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sec && $past(rd_sec) && rhold && $past(rhold)) |-> $stable(dq));

  p_idle_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sec |-> dq == 8'h00);

endmodule

bind rtc_trim_prescaler rtc_trim_prescaler_chk #(
  .TICKS_PER_SEC(TICKS_PER_SEC),
  .MAG_W(MAG_W),
  .PRE_W(PRE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .rd_sec(rd_sec), .dq(dq),
  .sec_pulse(sec_pulse), .sec_count(sec_count), .pre_cnt(pre_cnt),
  .probe(probe), .test_en(test_en), .whold(whold), .rhold(rhold)
);

// File: tb/tb_rtc_trim_prescaler.sv
`timescale 1ns/1ps
module tb_rtc_trim_prescaler;
  logic       clk = 1'b0;
  logic       rst_n, osc_tick, cfg_we, rd_sec;
  logic [1:0] cfg_sel;
  logic [7:0] cfg_wdata;
  logic [7:0] dq;
  logic       sec_pulse;
  logic [5:0] sec_count;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  // {calibration byte [21:16], expected ticks in that second [15:0]}, window = 2
  localparam logic [21:0] VEC [5] = '{
    {6'h00, 16'd32768},   // R2: trimmed slot, zero trim
    {6'h0A, 16'd32768},   // R5: untrimmed slot ignores -10
    {6'h0A, 16'd32778},   // R3: -10 lengthens
    {6'h2A, 16'd32768},   // R5: untrimmed slot ignores +10
    {6'h2A, 16'd32758}    // R4: +10 shortens
  };

  always #10 clk = ~clk;

  rtc_trim_prescaler #(.CAL_WINDOW(2)) dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .rd_sec(rd_sec), .dq(dq),
    .sec_pulse(sec_pulse), .sec_count(sec_count)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    cyc++;
  endtask

  task automatic run_ticks(input int n);
    osc_tick = 1'b1;
    repeat (n) @(negedge clk);
    osc_tick = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; osc_tick = 1'b0; cfg_we = 1'b0; rd_sec = 1'b0;
    cfg_sel = 2'd0; cfg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 195000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R1 sec_count", sec_count, 0);
    check("R1 sec_pulse", sec_pulse, 0);
    check("R11 dq idle", dq, 0);
    rd_sec = 1'b1;
    run_ticks(32);
    check("R1 test off after reset", dq, 0);
    cfg_write(2'd2, 8'h40);
    check("R8 days write without write-hold ignored", dq, 0);
    cfg_write(2'd0, 8'h80);
    cfg_write(2'd2, 8'h40);
    check("R7 probe on dq0 after 32 ticks", dq, 1);
    run_ticks(31);
    check("R6 probe high at tick 63", dq, 1);
    run_ticks(1);
    check("R6 probe low at tick 64", dq, 0);
    run_ticks(32);
    check("R6 probe high at tick 96", dq, 1);
    cfg_write(2'd0, 8'h40);
    check("R10 read-hold hides probe", dq, 0);
    cfg_write(2'd0, 8'h00);
    check("R10 read-hold released", dq, 1);
    cfg_write(2'd0, 8'h80);
    cfg_write(2'd2, 8'h00);
    check("R9 test cleared, seconds again", dq, 0);
    rd_sec = 1'b0;
    check("R11 dq idle when deselected", dq, 0);

    do_reset();
    osc_tick = 1'b1;
    for (int i = 0; i < 5; i++) begin
      cyc = 0;
      if (i == 2) begin
        cfg_write(2'd0, 8'h00);
        check("R10 live seconds after release", dq, 2);
      end
      cfg_write(2'd1, {2'b00, VEC[i][21:16]});
      if (i == 1) begin
        rd_sec = 1'b1;
        cfg_write(2'd0, 8'h40);
      end
      do begin
        @(negedge clk);
        cyc++;
      end while (!sec_pulse);
      check($sformatf("R2/R3/R4/R5 second %0d length", i), cyc, int'(VEC[i][15:0]));
      check("R2 sec_count advance", sec_count, i + 1);
      if (i == 1) check("R10 captured seconds held", dq, 1);
    end
    osc_tick = 1'b0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule